// File: doc/BRIEF.md
# Dual-channel serial ADC host controller

This block runs on the system clock and acts as the host for a two-input, 8-bit successive-approximation converter that sits on a four-wire serial link. It makes the serial clock by dividing the system clock, drives the active-low select line, shifts out a control byte on its data-out wire and shifts in the converter's reply. The reply comes back with the channel it belongs to, through a valid/ready output register.

Each conversion fills a window of sixteen serial-clock cycles. The control byte sent during a window names the input for the next window, so every result carries the tag of the request made one window earlier. The first window after select falls always converts input 1. A one-cycle `start_i` pulse gives one window. Holding `cont_i` high keeps select low and runs windows back to back. If the consumer still holds the previous result when a new one is ready, the new one is discarded and a one-cycle overrun flag is raised. The serial clock is never stalled.

Top module: `adcif_host`

## Requirements
- R1: While reset is held and right after it is released, select is high (1), the serial clock is high (1), control-data out is 0, and `smp_valid_o` and `smp_overrun_o` are 0.
- R2: While select is low, every low phase and every high phase of the serial clock inside a window lasts exactly `HALF_DIV` system clocks.
- R3: A `start_i` pulse in idle gives exactly one window. The window has 16 falling serial-clock edges and ends with select returning high. It delivers exactly one result.
- R4: Select falls exactly `HALF_DIV` system clocks before the first falling serial-clock edge. Whenever select is high, the serial clock is high, including the cycle in which select rises.
- R5: Control-data out changes only together with a falling serial-clock edge. In each window it carries the byte 0000_c000 MSB first over the first 8 rising edges, where c (bit 3) is `chan_sel_i` sampled at the window's first falling edge. It is 0 for the rest of the window.
- R6: The result is the 8 input bits sampled on rising serial-clock edges 4 to 11 of the window (counting from 0), the first of them being the MSB. Input bits at positions 0 to 3 and 12 to 15 have no effect.
- R7: The tag reported with a window's result is the channel requested in the previous window of the same select-low period (0 = input 1, 1 = input 2). The first window after select falls reports tag 0.
- R8: While `cont_i` is high at a window's end, select stays low and the next window's first falling edge follows the last rising edge after exactly `HALF_DIV` system clocks.
- R9: While `smp_valid_o` is 1 and `smp_ready_i` is 0, the valid flag, the data and the tag hold their values on the next cycle.
- R10: When a result completes while `smp_valid_o` is 1 and `smp_ready_i` is 0, `smp_overrun_o` pulses for one cycle. The held result stays unchanged and the new result is discarded.
- R11: Activity on `adc_data_i` while select is high produces no result and changes no later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one window when idle |
| cont_i | input | 1 | Keep converting back to back while high |
| chan_sel_i | input | 1 | Channel to request in the window being started (0 = input 1, 1 = input 2) |
| adc_cs_n_o | output | 1 | Active-low converter select |
| adc_sclk_o | output | 1 | Serial clock, idles high |
| adc_ctrl_o | output | 1 | Control data to converter, changes on falling edges |
| adc_data_i | input | 1 | Serial sample data from converter, sampled on rising edges |
| smp_valid_o | output | 1 | Result available |
| smp_ready_i | input | 1 | Consumer accepts the result |
| smp_data_o | output | 8 | Result, straight binary |
| smp_chan_o | output | 1 | Channel tag of the result |
| smp_overrun_o | output | 1 | One-cycle pulse: a result was discarded |

## Verification
A model of the converter on the bench answers each window with a value that depends on the channel and the window number. It includes all-ones and all-zeros results, and it drives ones on the bit positions outside the result window, so a capture window shifted by one position shows up at once. Runs with one window each, continuous runs with a changing channel sequence, a restart after a request for input 2, and a continuous run against a stalled consumer separate the one-window lag of the tag from the data path, and the held result from the discarded ones. Edge-timing monitors measure the phase widths, the gap between windows and the delay from select to the first clock edge. Toggling the data input while idle shows whether the input is sampled outside select.

// File: rtl/adcif_pkg.sv
package adcif_pkg;

    localparam int FRAME_CLKS  = 16;
    localparam int CTRL_BITS   = 8;
    localparam int SAMPLE_BITS = 8;
    localparam int DATA_FIRST  = 4;
    localparam int DATA_LAST   = DATA_FIRST + SAMPLE_BITS - 1;
    localparam int CHSEL_POS   = 3;
    localparam int BITCNT_W    = $clog2(FRAME_CLKS);

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_LEAD,
        FR_RUN
    } fr_state_e;

    typedef struct packed {
        logic                   chan;
        logic [SAMPLE_BITS-1:0] data;
    } sample_t;

    function automatic logic [CTRL_BITS-1:0] ctrl_word(input logic chan);
        logic [CTRL_BITS-1:0] w;
        w            = '0;
        w[CHSEL_POS] = chan;
        return w;
    endfunction

    function automatic logic in_data_window(input logic [BITCNT_W-1:0] pos);
        return (int'(pos) >= DATA_FIRST) && (int'(pos) <= DATA_LAST);
    endfunction

endpackage

// File: rtl/adcif_tick.sv
module adcif_tick #(
    parameter int HALF_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);

    generate
        if (HALF_DIV <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int            CW   = $clog2(HALF_DIV);
            localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == LAST);
        end
    endgenerate

endmodule

// File: rtl/adcif_frame.sv
module adcif_frame
    import adcif_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    go,
    input  logic    cont,
    input  logic    chan_req,
    input  logic    sdi,
    output logic    run,
    output logic    cs_n,
    output logic    sclk,
    output logic    sdo,
    output logic    done,
    output sample_t result
);

    fr_state_e               st;
    logic [BITCNT_W-1:0]     bitcnt;
    logic [CTRL_BITS-1:0]    ctrl_sh;
    logic [SAMPLE_BITS-1:0]  data_sh;
    logic                    req_chan;
    logic                    tag_chan;
    logic                    last_bit;
    logic                    frame_start;
    logic [CTRL_BITS-1:0]    next_ctrl;

    assign run         = (st != FR_IDLE);
    assign last_bit    = (bitcnt == BITCNT_W'(FRAME_CLKS - 1));
    assign next_ctrl   = ctrl_word(chan_req);
    assign frame_start = tick && ((st == FR_LEAD) ||
                                  ((st == FR_RUN) && sclk && last_bit && cont));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= FR_IDLE;
            cs_n     <= 1'b1;
            sclk     <= 1'b1;
            sdo      <= 1'b0;
            bitcnt   <= '0;
            ctrl_sh  <= '0;
            data_sh  <= '0;
            req_chan <= 1'b0;
            tag_chan <= 1'b0;
            done     <= 1'b0;
            result   <= '0;
        end else begin
            done <= 1'b0;
            if (frame_start) begin
                st       <= FR_RUN;
                sclk     <= 1'b0;
                bitcnt   <= '0;
                req_chan <= chan_req;
                sdo      <= next_ctrl[CTRL_BITS-1];
                ctrl_sh  <= {next_ctrl[CTRL_BITS-2:0], 1'b0};
            end else begin
                case (st)
                    FR_IDLE: begin
                        if (go) begin
                            st       <= FR_LEAD;
                            cs_n     <= 1'b0;
                            tag_chan <= 1'b0;
                        end
                    end
                    FR_RUN: begin
                        if (tick) begin
                            if (!sclk) begin
                                sclk <= 1'b1;
                                if (in_data_window(bitcnt)) begin
                                    data_sh <= {data_sh[SAMPLE_BITS-2:0], sdi};
                                end
                                if (last_bit) begin
                                    done     <= 1'b1;
                                    result   <= '{chan: tag_chan, data: data_sh};
                                    tag_chan <= req_chan;
                                end
                            end else if (last_bit) begin
                                st   <= FR_IDLE;
                                cs_n <= 1'b1;
                            end else begin
                                sclk    <= 1'b0;
                                bitcnt  <= bitcnt + 1'b1;
                                sdo     <= ctrl_sh[CTRL_BITS-1];
                                ctrl_sh <= {ctrl_sh[CTRL_BITS-2:0], 1'b0};
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: the serial clock rests high whenever select is released
    a_r4_idle_sclk_high: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    // R4: select only rises while the clock was already high
    a_r4_cs_rise_clk_high: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> $past(sclk));

    // R5: control data moves only with a falling clock edge
    a_r5_sdo_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo) |-> $fell(sclk));

    // R8: clock edges occur only inside a select-low period
    a_r8_fall_under_cs: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> !cs_n);

endmodule

// File: rtl/adcif_outreg.sv
module adcif_outreg
    import adcif_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  sample_t item,
    input  logic    ready,
    output logic    valid,
    output sample_t held,
    output logic    overrun
);

    logic blocked;

    assign blocked = valid && !ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            held    <= '0;
            overrun <= 1'b0;
        end else begin
            overrun <= push && blocked;
            if (push && !blocked) begin
                valid <= 1'b1;
                held  <= item;
            end else if (valid && ready) begin
                valid <= 1'b0;
            end
        end
    end

    // R9: a stalled result is held unchanged
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(held));

    // R10: overrun only follows a stall, and the held result survives
    a_r10_overrun: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(valid && !ready) && valid);

endmodule

// File: rtl/adcif_host.sv
module adcif_host
    import adcif_pkg::*;
#(
    parameter int HALF_DIV = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic                   cont_i,
    input  logic                   chan_sel_i,
    output logic                   adc_cs_n_o,
    output logic                   adc_sclk_o,
    output logic                   adc_ctrl_o,
    input  logic                   adc_data_i,
    output logic                   smp_valid_o,
    input  logic                   smp_ready_i,
    output logic [SAMPLE_BITS-1:0] smp_data_o,
    output logic                   smp_chan_o,
    output logic                   smp_overrun_o
);

    logic    tick;
    logic    run;
    logic    done;
    sample_t res;
    sample_t held;

    adcif_tick #(
        .HALF_DIV(HALF_DIV)
    ) u_tick (
        .clk (clk),
        .rst (rst),
        .run (run),
        .tick(tick)
    );

    adcif_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .go      (start_i | cont_i),
        .cont    (cont_i),
        .chan_req(chan_sel_i),
        .sdi     (adc_data_i),
        .run     (run),
        .cs_n    (adc_cs_n_o),
        .sclk    (adc_sclk_o),
        .sdo     (adc_ctrl_o),
        .done    (done),
        .result  (res)
    );

    adcif_outreg u_out (
        .clk    (clk),
        .rst    (rst),
        .push   (done),
        .item   (res),
        .ready  (smp_ready_i),
        .valid  (smp_valid_o),
        .held   (held),
        .overrun(smp_overrun_o)
    );

    assign smp_data_o = held.data;
    assign smp_chan_o = held.chan;

    // R1: nothing is offered while select has never been driven low
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n_o && $past(adc_cs_n_o) && !smp_valid_o |=> !smp_overrun_o);

endmodule

// File: tb/test_adcif_host.sv
module test_adcif_host;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       cont_i = 1'b0;
    logic       chan_sel = 1'b0;
    logic       cs_n, sclk, ctrl;
    logic       adc_data;
    logic       valid;
    logic       ready = 1'b1;
    logic [7:0] data;
    logic       chan;
    logic       ovr;

    always #10 clk = ~clk;

    adcif_host #(.HALF_DIV(HALF)) i_adcif_host (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .cont_i       (cont_i),
        .chan_sel_i   (chan_sel),
        .adc_cs_n_o   (cs_n),
        .adc_sclk_o   (sclk),
        .adc_ctrl_o   (ctrl),
        .adc_data_i   (adc_data),
        .smp_valid_o  (valid),
        .smp_ready_i  (ready),
        .smp_data_o   (data),
        .smp_chan_o   (chan),
        .smp_overrun_o(ovr)
    );

    int checks = 0;
    int errors = 0;
    bit done_run = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // ---------------- converter model (driver side of the scoreboard) ----------------
    logic       idle_level = 1'b1;
    logic       mdl_dout = 1'b1;
    int         m_idx = 0;
    int         m_frame = 0;
    logic       m_ch = 1'b0;
    logic       m_req = 1'b0;
    logic [7:0] m_word = 8'h00;
    logic [7:0] m_ctrl = 8'h00;
    logic [8:0] expq[$];
    event       frame_ev;

    assign adc_data = cs_n ? idle_level : mdl_dout;

    function automatic logic [7:0] val(input logic ch, input int n);
        case (n % 5)
            1:       return 8'hFF;
            2:       return 8'h00;
            default: return ch ? (8'hC3 ^ 8'(n * 17)) : (8'h5A + 8'(n * 39));
        endcase
    endfunction

    always @(negedge cs_n) begin
        m_idx  = 0;
        m_ch   = 1'b0;
        m_ctrl = 8'h00;
        m_word = val(1'b0, m_frame);
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            if (m_idx == 0) m_req = chan_sel;
            // ones outside the result window prove those positions are ignored (R6)
            mdl_dout = (m_idx >= 4 && m_idx <= 11) ? m_word[11 - m_idx] : 1'b1;
        end
    end

    always @(posedge sclk) begin
        if (!cs_n) begin
            if (m_idx < 8) m_ctrl = {m_ctrl[6:0], ctrl};
            if (m_idx == 15) begin
                chk(m_ctrl == {4'b0000, m_req, 3'b000}, "R5 control byte",
                    int'(m_ctrl), int'({4'b0000, m_req, 3'b000}));
                expq.push_back({m_ch, m_word});
                m_ch = m_ctrl[3];
                m_frame++;
                m_word = val(m_ch, m_frame);
                m_idx  = 0;
                -> frame_ev;
            end else begin
                m_idx++;
            end
        end
    end

    // ---------------- edge-timing monitor ----------------
    logic p_sclk = 1'b1;
    logic p_cs = 1'b1;
    int   hi_len = 0, lo_len = 0, since_cs = 0, falls = 0, burst_falls = 0;
    bit   first_fall = 0;

    always @(negedge clk) begin
        if (!rst) begin
            hi_len++;
            lo_len++;
            since_cs++;
            if (p_cs && !cs_n) begin
                since_cs   = 0;
                falls      = 0;
                first_fall = 1;
            end
            if (p_sclk && !sclk) begin
                if (first_fall)
                    chk(since_cs == HALF, "R4 select lead", since_cs, HALF);
                else if (falls % 16 == 0)
                    chk(hi_len == HALF, "R8 window gap", hi_len, HALF);
                else
                    chk(hi_len == HALF, "R2 high phase", hi_len, HALF);
                first_fall = 0;
                falls++;
                lo_len = 0;
            end else if (!p_sclk && sclk) begin
                chk(lo_len == HALF, "R2 low phase", lo_len, HALF);
                hi_len = 0;
            end
            if (!p_cs && cs_n) begin
                burst_falls = falls;
                chk(sclk == 1'b1, "R4 clock high at select rise", int'(sclk), 1);
            end
            if (cs_n) chk(sclk == 1'b1, "R4 idle clock", int'(sclk), 1);
            p_sclk = sclk;
            p_cs   = cs_n;
        end
    end

    // ---------------- result monitor / scoreboard ----------------
    int         popped = 0;
    int         ovr_seen = 0;
    logic       last_chan = 1'b0;
    bit         p_blocked = 0;
    logic [8:0] p_item = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (ovr) begin
                ovr_seen++;
                if (expq.size() > 0) void'(expq.pop_back());
            end
            if (p_blocked)
                chk(valid && ({chan, data} == p_item), "R9 hold", int'({chan, data}), int'(p_item));
            if (valid && ready) begin
                if (expq.size() == 0) begin
                    chk(0, "R6 unexpected result", int'({chan, data}), 0);
                end else begin
                    logic [8:0] e;
                    e = expq.pop_front();
                    chk(data == e[7:0], "R6 data", int'(data), int'(e[7:0]));
                    chk(chan == e[8], "R7 tag", int'(chan), int'(e[8]));
                end
                popped++;
                last_chan = chan;
            end
            p_blocked = valid && !ready;
            p_item    = {chan, data};
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(cs_n == 1'b1, "R1 select", int'(cs_n), 1);
        chk(sclk == 1'b1, "R1 clock", int'(sclk), 1);
        chk(ctrl == 1'b0, "R1 control", int'(ctrl), 0);
        chk(valid == 1'b0, "R1 valid", int'(valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b1 && !valid && !ovr, "R1 after release",
            int'({cs_n, sclk, valid, ovr}), 'b1100);

        // single window requesting input 2; tag must still be 0 (R3, R7)
        chan_sel = 1'b1;
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(posedge cs_n);
        repeat (6) @(negedge clk);
        chk(burst_falls == 16, "R3 edges per window", burst_falls, 16);
        chk(popped == 1, "R3 one result", popped, 1);
        chk(last_chan == 1'b0, "R7 first window tag", int'(last_chan), 0);

        // data input toggles while select is high (R11)
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            idle_level = ~idle_level;
        end
        chk(!valid && popped == 1, "R11 idle input ignored", popped, 1);
        chk(cs_n == 1'b1, "R11 stays idle", int'(cs_n), 1);

        // continuous run, request sequence 1,0,1,1 -> tags 0,1,0,1 (R7, R8)
        chan_sel = 1'b1;
        cont_i   = 1'b1;
        @(frame_ev); chan_sel = 1'b0;
        @(frame_ev); chan_sel = 1'b1;
        @(frame_ev); chan_sel = 1'b1;
        @(frame_ev); cont_i = 1'b0;
        @(posedge cs_n);
        repeat (6) @(negedge clk);
        chk(burst_falls == 64, "R8 four windows back to back", burst_falls, 64);
        chk(popped == 5, "R8 four results", popped, 5);

        // restart after a request for input 2: first tag is 0 again (R7)
        chan_sel = 1'b0;
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(posedge cs_n);
        repeat (6) @(negedge clk);
        chk(last_chan == 1'b0, "R7 restart tag", int'(last_chan), 0);
        chk(popped == 6, "R3 restart result", popped, 6);

        // stalled consumer over three windows (R9, R10)
        ready    = 1'b0;
        chan_sel = 1'b1;
        cont_i   = 1'b1;
        @(frame_ev);
        @(frame_ev);
        @(frame_ev); cont_i = 1'b0;
        @(posedge cs_n);
        repeat (6) @(negedge clk);
        chk(ovr_seen == 2, "R10 overrun pulses", ovr_seen, 2);
        chk(valid == 1'b1, "R10 held result", int'(valid), 1);
        @(negedge clk);
        ready = 1'b1;
        repeat (4) @(negedge clk);
        chk(popped == 7, "R10 one kept", popped, 7);
        chk(expq.size() == 0, "R10 discarded results", expq.size(), 0);
        chk(!valid, "R9 released", int'(valid), 0);

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R3 actual=timeout expected=finish");
        finish_run();
    end

endmodule